// File: doc/BRIEF.md
# Serial Command Decoder with Handshaked Strobe Flags

This block receives commands one bit at a time. Every rising edge of the write strobe shifts the most significant bit of the command bus into a 16-bit register. No frame counter or length gate exists, so the register shifts on every strobe. After each shift, a combinational decoder compares the register contents with two command addresses. These are the command frame (low byte `0x53`) and the execute frame (low byte `0x58`). The decode is qualified by two status inputs and a 3-bit select input. Both addresses share one common term, and each then adds its own remaining terms.

The decode results are captured in edge-triggered flops on the same strobe edge. A frame that is only partly shifted in therefore cannot raise an output before its last bit arrives. A command frame carries a 3-bit code. Four of the codes set sticky request flags for a controller running on its own clock. Each flag is cleared asynchronously by an acknowledge from that controller. A two-flop synchroniser in the controller domain brings each flag across. A fifth code produces a mask-write strobe, which is gated by the write strobe itself.

Top module: `serial_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, `cmd_hit`, `exec_hit`, `mask_wr` and all request flags are 0. While `fsm_rst_n` is low, `req_sync` is 0.
- R2: On each rising `wr_clk` edge, `cmd_bit` enters bit 0 and the older bits move one place up, so the first bit shifted of 16 ends in bit 15. All outputs of the write domain change only at rising `wr_clk` edges.
- R3: `cmd_hit` is 1 after an edge exactly when the shifted word has bits 7..0 = `8'h53` and bits 15..11 = `5'b00110`, with `halt_in`=0, `wait_in`=0, `sel[1]`=1 and `sel[0]`=0.
- R4: `exec_hit` is 1 after an edge exactly when bits 7..0 = `8'h58`, `halt_in`=0, `wait_in`=0, `sel[2]`=1 and `sel[1]`=0. Bits 15..8 are don't-care for this frame.
- R5: While `halt_in` or `wait_in` is 1, neither frame is recognised and no flag or strobe results.
- R6: On a recognised command frame, the code in bits 10..8 acts as follows: 0 sets request flag 0 (start), 1 sets flag 1 (step), 2 sets flag 2 (stop), 3 sets flag 3 (reset), 4 selects a mask write, and 5 to 7 do nothing.
- R7: `mask_wr` is high only while `wr_clk` is high, and only after an edge that completed a mask-write frame. It is low whenever `wr_clk` is low.
- R8: A request flag stays set until its `req_ack` bit goes high, which clears it immediately. A set request that arrives while the acknowledge is high is lost.
- R9: `req_sync[i]` follows flag i through two `fsm_clk` flops. A flag set once and acknowledged with a full handshake (acknowledge held until `req_sync[i]` reads 0) gives exactly one high pulse on `req_sync[i]`.
- R10: Frames matching neither address, including command frames with one bit in error, leave `cmd_hit`, `exec_hit`, `mask_wr` and the flags unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write strobe; clocks the shift register and capture flops |
| rst_n | input | 1 | Asynchronous active-low reset of the write domain |
| cmd_bit | input | 1 | Serial data, the MSB of the command bus |
| halt_in | input | 1 | Status qualifier; blocks decoding when 1 |
| wait_in | input | 1 | Status qualifier; blocks decoding when 1 |
| sel | input | 3 | Select lines qualifying the two addresses |
| fsm_clk | input | 1 | Controller clock |
| fsm_rst_n | input | 1 | Asynchronous active-low reset of the synchronisers |
| req_ack | input | 4 | Asynchronous clear, one per request flag |
| cmd_hit | output | 1 | Captured command-frame match |
| exec_hit | output | 1 | Captured execute-frame match |
| mask_wr | output | 1 | Mask-write strobe, gated by `wr_clk` |
| req_sync | output | 4 | Request flags synchronised to `fsm_clk` |

## Verification
The assertions assume the following about the inputs. `halt_in`, `wait_in` and `sel` are stable around each rising `wr_clk` edge. `req_ack` and `wr_clk` change away from rising `fsm_clk` edges. An acknowledge that is sampled high has already cleared its flag. The stimulus meets all of this. Every input moves on a falling `fsm_clk` edge, and the qualifiers change only between frames. The acknowledge follows the full handshake, except in one directed case that raises it before the set arrives.

// File: rtl/serial_cmd_pkg.sv
package serial_cmd_pkg;

    localparam int unsigned FRAME_W  = 16;
    localparam int unsigned N_REQ    = 4;
    localparam int unsigned CODE_W   = 3;
    localparam int unsigned CODE_LSB = 8;

    localparam logic [7:0] CMD_LOW_BYTE  = 8'h53;
    localparam logic [4:0] CMD_HIGH_BITS = 5'b00110;
    localparam logic [7:0] EXE_LOW_BYTE  = 8'h58;

    localparam logic [CODE_W-1:0] CODE_MASK = 3'd4;

    typedef struct packed {
        logic             cmd_hit;
        logic             exec_hit;
        logic             mask_sel;
        logic [N_REQ-1:0] req_set;
    } dec_res_t;

endpackage

// File: rtl/cmd_shift_reg.sv
module cmd_shift_reg #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [WIDTH-1:0] word_next,
    output logic [WIDTH-1:0] word_q
);
    logic [WIDTH-1:0] word_d;

    always_comb begin
        word_d = {word_q[WIDTH-2:0], din};
    end

    assign word_next = word_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end
endmodule

// File: rtl/cmd_addr_decode.sv
module cmd_addr_decode
    import serial_cmd_pkg::*;
(
    input  logic [FRAME_W-1:0] word,
    input  logic               halt_in,
    input  logic               wait_in,
    input  logic [2:0]         sel,
    output dec_res_t           res
);
    logic              common;
    logic              s_own;
    logic              x_own;
    logic [CODE_W-1:0] code;

    always_comb begin
        // Terms shared by both addresses: high nibble 0101, bit 2 clear, qualifiers idle
        common = word[6] & word[4]
               & ~(halt_in | wait_in | word[2] | word[7] | word[5]);
        s_own  = word[1] & word[0] & ~word[3]
               & (word[FRAME_W-1 -: 5] == CMD_HIGH_BITS)
               & sel[1] & ~sel[0];
        x_own  = word[3] & ~word[1] & ~word[0] & sel[2] & ~sel[1];
        code   = word[CODE_LSB +: CODE_W];

        res          = '0;
        res.cmd_hit  = common & s_own;
        res.exec_hit = common & x_own;
        res.mask_sel = res.cmd_hit & (code == CODE_MASK);
        for (int i = 0; i < N_REQ; i++) begin
            res.req_set[i] = res.cmd_hit & (code == CODE_W'(i));
        end
    end
endmodule

// File: rtl/req_flag_cell.sv
module req_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    output logic flag_q
);
    logic flag_d;

    always_comb begin
        flag_d = flag_q | set;
    end

    always_ff @(posedge clk or negedge rst_n or posedge clr) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (clr) flag_q <= 1'b0;
        else          flag_q <= flag_d;
    end
endmodule

// File: rtl/req_sync.sv
module req_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
    import serial_cmd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             wr_clk,
    input  logic             rst_n,
    input  logic             cmd_bit,
    input  logic             halt_in,
    input  logic             wait_in,
    input  logic [2:0]       sel,
    input  logic             fsm_clk,
    input  logic             fsm_rst_n,
    input  logic [N_REQ-1:0] req_ack,
    output logic             cmd_hit,
    output logic             exec_hit,
    output logic             mask_wr,
    output logic [N_REQ-1:0] req_sync
);
    typedef struct packed {
        logic cmd_hit;
        logic exec_hit;
        logic mask_sel;
    } cap_t;

    logic [FRAME_W-1:0] word_next;
    logic [FRAME_W-1:0] word_q;
    dec_res_t           dec;
    cap_t               cap_d;
    cap_t               cap_q;
    logic [N_REQ-1:0]   req_flag;

    cmd_shift_reg #(.WIDTH(FRAME_W)) u_shift (
        .clk      (wr_clk),
        .rst_n    (rst_n),
        .din      (cmd_bit),
        .word_next(word_next),
        .word_q   (word_q)
    );

    // Decode the word as it will stand after this edge, so capture lands on the last bit
    cmd_addr_decode u_dec (
        .word   (word_next),
        .halt_in(halt_in),
        .wait_in(wait_in),
        .sel    (sel),
        .res    (dec)
    );

    always_comb begin
        cap_d          = cap_q;
        cap_d.cmd_hit  = dec.cmd_hit;
        cap_d.exec_hit = dec.exec_hit;
        cap_d.mask_sel = dec.mask_sel;
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    generate
        for (genvar i = 0; i < N_REQ; i++) begin : g_req
            req_flag_cell u_flag (
                .clk   (wr_clk),
                .rst_n (rst_n),
                .clr   (req_ack[i]),
                .set   (dec.req_set[i]),
                .flag_q(req_flag[i])
            );
            req_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (fsm_clk),
                .rst_n(fsm_rst_n),
                .din  (req_flag[i]),
                .dout (req_sync[i])
            );
        end
    endgenerate

    assign cmd_hit  = cap_q.cmd_hit;
    assign exec_hit = cap_q.exec_hit;
    assign mask_wr  = cap_q.mask_sel & wr_clk;
endmodule

// File: rtl/serial_cmd_decoder_chk.sv
module serial_cmd_decoder_chk
    import serial_cmd_pkg::*;
(
    input logic             wr_clk,
    input logic             rst_n,
    input logic             halt_in,
    input logic             wait_in,
    input logic             fsm_clk,
    input logic             fsm_rst_n,
    input logic [N_REQ-1:0] req_ack,
    input logic [N_REQ-1:0] req_flag,
    input logic             cmd_hit,
    input logic             exec_hit,
    input logic             mask_wr
);
    AST_MASK_NEEDS_STROBE: assert property (@(posedge fsm_clk) disable iff (!rst_n)
        !wr_clk |-> !mask_wr); // R7

    AST_HITS_EXCLUSIVE: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !(cmd_hit && exec_hit)); // R4

    AST_QUAL_BLOCKS_HIT: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (cmd_hit || exec_hit) |-> $past(!halt_in && !wait_in)); // R5

    generate
        for (genvar i = 0; i < N_REQ; i++) begin : g_ack
            AST_ACK_CLEARS_FLAG: assert property (@(posedge fsm_clk)
                disable iff (!rst_n || !fsm_rst_n)
                req_ack[i] |-> !req_flag[i]); // R8
        end
    endgenerate
endmodule

bind serial_cmd_decoder serial_cmd_decoder_chk u_chk (
    .wr_clk   (wr_clk),
    .rst_n    (rst_n),
    .halt_in  (halt_in),
    .wait_in  (wait_in),
    .fsm_clk  (fsm_clk),
    .fsm_rst_n(fsm_rst_n),
    .req_ack  (req_ack),
    .req_flag (req_flag),
    .cmd_hit  (cmd_hit),
    .exec_hit (exec_hit),
    .mask_wr  (mask_wr)
);

// File: tb/tb_serial_cmd_decoder.sv
module tb_serial_cmd_decoder;
    logic       wr_clk = 1'b0, rst_n = 1'b0, cmd_bit = 1'b0;
    logic       halt_in = 1'b0, wait_in = 1'b0;
    logic [2:0] sel = 3'b000;
    logic       fsm_clk = 1'b0, fsm_rst_n = 1'b0;
    logic [3:0] req_ack = 4'b0;
    logic       cmd_hit, exec_hit, mask_wr;
    logic [3:0] req_sync;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [15:0] m_word = '0;
    logic [3:0]  m_flag = '0;
    logic        m_cmd = 0, m_exe = 0, m_mask = 0;

    serial_cmd_decoder dut (.*);

    always #2 fsm_clk = ~fsm_clk;   // 250 MHz

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic f_cmd(logic [15:0] w, logic h, logic wt, logic [2:0] s);
        return w[7:0] == 8'h53 && w[15:11] == 5'b00110 && !h && !wt && s[1] && !s[0];
    endfunction
    function automatic logic f_exe(logic [15:0] w, logic h, logic wt, logic [2:0] s);
        return w[7:0] == 8'h58 && !h && !wt && s[2] && !s[1];
    endfunction

    task automatic shift_bit(input logic b);
        @(negedge fsm_clk); cmd_bit = b;
        @(negedge fsm_clk); wr_clk = 1'b1;
        m_word = {m_word[14:0], b};                             // R2
        m_cmd  = f_cmd(m_word, halt_in, wait_in, sel);
        m_exe  = f_exe(m_word, halt_in, wait_in, sel);
        m_mask = m_cmd && m_word[10:8] == 3'd4;
        for (int i = 0; i < 4; i++)
            if (m_cmd && m_word[10:8] == 3'(i) && !req_ack[i]) m_flag[i] = 1'b1;
        #1;
        check("R3 cmd_hit", 8'(cmd_hit), 8'(m_cmd));
        check("R4 exec_hit", 8'(exec_hit), 8'(m_exe));
        check("R7 mask_wr high phase", 8'(mask_wr), 8'(m_mask));
        @(negedge fsm_clk); wr_clk = 1'b0;
        #1;
        check("R7 mask_wr low phase", 8'(mask_wr), 8'h0);
        check("R2 cmd_hit held", 8'(cmd_hit), 8'(m_cmd));
    endtask

    task automatic send_frame(input logic [15:0] f);
        for (int b = 15; b >= 0; b--) shift_bit(f[b]);
    endtask

    // Acts as the controller: full handshake on every flag, one event each
    task automatic service_flags();
        for (int i = 0; i < 4; i++) begin
            int waited = 0;
            if (m_flag[i]) begin
                while (req_sync[i] !== 1'b1 && waited < 8) begin
                    @(negedge fsm_clk); waited++;
                end
                check("R9 req_sync rises", 8'(req_sync[i]), 8'h1);
                req_ack[i] = 1'b1;
                waited = 0;
                while (req_sync[i] !== 1'b0 && waited < 8) begin
                    @(negedge fsm_clk); waited++;
                end
                check("R8 ack clears", 8'(req_sync[i]), 8'h0);
                req_ack[i] = 1'b0;
                m_flag[i] = 1'b0;
            end
            repeat (4) @(negedge fsm_clk);
            check("R9 single event", 8'(req_sync[i]), 8'h0);
        end
    endtask

    function automatic logic [15:0] cmd_frame(logic [2:0] code);
        return {5'b00110, code, 8'h53};
    endfunction

    initial begin
        #60000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge fsm_clk);
        check("R1 cmd_hit reset", 8'(cmd_hit), 8'h0);
        check("R1 exec_hit reset", 8'(exec_hit), 8'h0);
        check("R1 mask_wr reset", 8'(mask_wr), 8'h0);
        check("R1 req_sync reset", 8'(req_sync), 8'h0);
        rst_n = 1'b1; fsm_rst_n = 1'b1;

        // Directed cases
        sel = 3'b010;
        for (int c = 0; c < 8; c++) begin send_frame(cmd_frame(3'(c))); service_flags(); end // R6
        halt_in = 1'b1; send_frame(cmd_frame(3'd0)); service_flags(); halt_in = 1'b0;      // R5
        wait_in = 1'b1; send_frame(cmd_frame(3'd1)); service_flags(); wait_in = 1'b0;      // R5
        sel = 3'b011; send_frame(cmd_frame(3'd2)); service_flags();                        // R3
        sel = 3'b100; send_frame(16'hA558); service_flags();                               // R4
        sel = 3'b110; send_frame(16'h0058); service_flags();                               // R4
        sel = 3'b010; send_frame(cmd_frame(3'd3) ^ 16'h0004); service_flags();             // R10
        req_ack[0] = 1'b1; send_frame(cmd_frame(3'd0));                                    // R8
        @(negedge fsm_clk); req_ack[0] = 1'b0;
        service_flags();
        check("R8 set lost under ack", 8'(req_sync[0]), 8'h0);

        // Constrained random frames
        for (int n = 0; n < 40; n++) begin
            int kind = $urandom % 4;
            logic [15:0] f;
            case (kind)
                0: f = cmd_frame(3'($urandom));
                1: f = {8'($urandom), 8'h58};
                2: f = 16'($urandom);
                default: f = cmd_frame(3'($urandom)) ^ (16'h1 << ($urandom % 16)); // R10
            endcase
            halt_in = ($urandom % 6) == 0;
            wait_in = ($urandom % 6) == 0;
            if ($urandom % 2) sel = (kind == 1) ? 3'b100 : 3'b010;
            else              sel = 3'($urandom);
            send_frame(f);
            service_flags();
        end

        rst_n = 1'b0; fsm_rst_n = 1'b0; #1;
        check("R1 reset again", 8'({cmd_hit, exec_hit, mask_wr, req_sync}), 8'h0);
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule